// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence State Tracker

This block holds the coherence state of every line of one private cache that sits on a shared, snooped bus using write-invalidate. It does not store data or tags. It decides three things: what the local core's loads and stores must put on the bus, how snooped traffic from other cores changes the local copies, and when a dirty line must be written back. A parameter chooses between a three-state protocol (Invalid, Shared, Modified) and a four-state protocol that adds Exclusive. With Exclusive, a store to a line that no other cache holds needs no bus transaction.

Each processor request is a single-cycle pulse carrying a line index and a read/write flag. The bus command for that request appears on `bus_cmd` in the same cycle. In the four-state variant, the sharer indication from other caches is sampled in that same cycle. A snooped transaction is also a single-cycle pulse, and `flush_req` and `shared_rsp` answer it combinationally in the same cycle. Every state change takes effect at the next rising clock edge. A separate probe index reads the state of any line.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid. States read on `probe_state` are encoded as 0 = Invalid, 1 = Shared, 2 = Exclusive, 3 = Modified.
- R2: A load to an Invalid line drives `bus_cmd` = 1 (read) in the request cycle. In the three-state variant the line then becomes Shared.
- R3: In the four-state variant, a load miss fills the line as Exclusive when `own_shared_in` is low and as Shared when it is high. In the three-state variant no line is ever Exclusive.
- R4: A store to an Invalid or Shared line drives `bus_cmd` = 2 (read-for-ownership), and the line becomes Modified.
- R5: A store to an Exclusive line drives `bus_cmd` = 0 (none), and the line becomes Modified.
- R6: Loads to Shared, Exclusive or Modified lines and stores to Modified lines drive `bus_cmd` = 0 and leave the state unchanged.
- R7: A snooped read (`snoop_rdx` = 0) to a Modified line raises `flush_req`, and the line becomes Shared. A snooped read to an Exclusive line makes it Shared without a flush. A Shared line stays Shared.
- R8: A snooped read-for-ownership (`snoop_rdx` = 1) to any valid line makes it Invalid. It raises `flush_req` only when the line was Modified.
- R9: `shared_rsp` is high exactly when a snooped read hits a valid line.
- R10: A snoop of either kind to an Invalid line raises neither `flush_req` nor `shared_rsp` and leaves the line Invalid.
- R11: A processor request and a snoop to different lines in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, one cycle |
| cpu_wr | input | 1 | 1 = store, 0 = load |
| cpu_idx | input | IDX_W | Line index of the request |
| own_shared_in | input | 1 | Other caches hold the line, sampled with own loads |
| snoop_vld | input | 1 | Snooped transaction from another core |
| snoop_rdx | input | 1 | 1 = read-for-ownership, 0 = read |
| snoop_idx | input | IDX_W | Line index of the snooped transaction |
| probe_idx | input | IDX_W | Line whose state is read out |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-for-ownership |
| flush_req | output | 1 | Write back the dirty line being snooped |
| shared_rsp | output | 1 | This cache holds the snooped line |
| probe_state | output | 2 | State of line `probe_idx` |

## Verification
The assertions assume that a processor request and a snoop never name the same line in the same cycle, because the caller serialises a local request against bus traffic to the same line. They also assume that `snoop_idx` and `cpu_idx` are always in range. The stimulus meets these assumptions. Same-cycle traffic is applied only to two different lines, and every index stays inside the parameterised line count. The same pulses drive a four-state instance and a three-state instance side by side, so each step checks how the two variants differ.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LN_I = 2'd0,
      LN_S = 2'd1,
      LN_E = 2'd2,
      LN_M = 2'd3
   } line_st_t;

   typedef enum logic [1:0] {
      BUS_NONE = 2'd0,
      BUS_RD   = 2'd1,
      BUS_RDX  = 2'd2
   } bus_cmd_t;

   typedef struct packed {
      logic     we;
      line_st_t nxt;
   } st_upd_t;

endpackage

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
   import coh_pkg::*;
#(
   parameter bit ALLOW_EXCL = 1'b1
) (
   input  logic     req,
   input  logic     wr,
   input  line_st_t cur,
   input  logic     shared_in,
   output bus_cmd_t cmd,
   output st_upd_t  upd
);

   line_st_t fill_st;

   // Variant choice: fill state of a read miss
   generate
      if (ALLOW_EXCL) begin : g_fill_mesi
         assign fill_st = shared_in ? LN_S : LN_E;
      end else begin : g_fill_msi
         assign fill_st = LN_S;
      end
   endgenerate

   always_comb begin
      cmd     = BUS_NONE;
      upd.we  = 1'b0;
      upd.nxt = cur;
      if (req) begin
         if (wr) begin
            unique case (cur)
               LN_M: ;
               LN_E: begin
                  upd.we  = 1'b1;
                  upd.nxt = LN_M;
               end
               default: begin
                  cmd     = BUS_RDX;
                  upd.we  = 1'b1;
                  upd.nxt = LN_M;
               end
            endcase
         end else if (cur == LN_I) begin
            cmd     = BUS_RD;
            upd.we  = 1'b1;
            upd.nxt = fill_st;
         end
      end
   end

endmodule

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
   import coh_pkg::*;
(
   input  logic     vld,
   input  logic     is_rdx,
   input  line_st_t cur,
   output logic     flush,
   output logic     shared_out,
   output st_upd_t  upd
);

   logic hit;

   assign hit = vld && (cur != LN_I);

   always_comb begin
      flush      = 1'b0;
      shared_out = 1'b0;
      upd.we     = 1'b0;
      upd.nxt    = cur;
      if (hit) begin
         flush      = (cur == LN_M);
         shared_out = !is_rdx;
         upd.we     = 1'b1;
         upd.nxt    = is_rdx ? LN_I : LN_S;
      end
   end

endmodule

// File: rtl/coh_state_array.sv
module coh_state_array
   import coh_pkg::*;
#(
   parameter int LINES = 16,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  st_upd_t               cpu_upd,
   input  logic [IDX_W-1:0]      cpu_idx,
   input  st_upd_t               snp_upd,
   input  logic [IDX_W-1:0]      snp_idx,
   output line_st_t [LINES-1:0]  st_all
);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_all[g] <= LN_I;
         end else if (snp_upd.we && snp_idx == IDX_W'(g)) begin
            st_all[g] <= snp_upd.nxt;
         end else if (cpu_upd.we && cpu_idx == IDX_W'(g)) begin
            st_all[g] <= cpu_upd.nxt;
         end
      end
   end

   // R11: the two write ports never name the same line together
   p_port_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_upd.we && snp_upd.we) |-> (cpu_idx != snp_idx));

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_pkg::*;
#(
   parameter int LINES      = 16,
   parameter bit ALLOW_EXCL = 1'b1,
   localparam int IDX_W     = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_wr,
   input  logic [IDX_W-1:0] cpu_idx,
   input  logic             own_shared_in,
   input  logic             snoop_vld,
   input  logic             snoop_rdx,
   input  logic [IDX_W-1:0] snoop_idx,
   input  logic [IDX_W-1:0] probe_idx,
   output logic [1:0]       bus_cmd,
   output logic             flush_req,
   output logic             shared_rsp,
   output logic [1:0]       probe_state
);

   generate
      if (LINES < 2) begin : g_bad_lines
         $error("coh_line_ctrl: LINES must be at least 2");
      end
      if ((1 << IDX_W) != LINES) begin : g_bad_pow2
         $error("coh_line_ctrl: LINES must be a power of two");
      end
   endgenerate

   line_st_t [LINES-1:0] st_all;
   line_st_t             cpu_cur;
   line_st_t             snp_cur;
   bus_cmd_t             cmd;
   st_upd_t              cpu_upd;
   st_upd_t              snp_upd;

   assign cpu_cur = st_all[cpu_idx];
   assign snp_cur = st_all[snoop_idx];

   coh_cpu_fsm #(.ALLOW_EXCL(ALLOW_EXCL)) u_cpu (
      .req       (cpu_req),
      .wr        (cpu_wr),
      .cur       (cpu_cur),
      .shared_in (own_shared_in),
      .cmd       (cmd),
      .upd       (cpu_upd)
   );

   coh_snoop_fsm u_snp (
      .vld        (snoop_vld),
      .is_rdx     (snoop_rdx),
      .cur        (snp_cur),
      .flush      (flush_req),
      .shared_out (shared_rsp),
      .upd        (snp_upd)
   );

   coh_state_array #(.LINES(LINES), .IDX_W(IDX_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_upd (cpu_upd),
      .cpu_idx (cpu_idx),
      .snp_upd (snp_upd),
      .snp_idx (snoop_idx),
      .st_all  (st_all)
   );

   assign bus_cmd     = cmd;
   assign probe_state = st_all[probe_idx];

   // R2: a load to an Invalid line goes to the bus as a read
   p_miss_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_wr && cpu_cur == LN_I) |-> (bus_cmd == BUS_RD));

   // R4: every store leaves its line Modified
   p_store_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_wr) |=> (st_all[$past(cpu_idx)] == LN_M));

   // R6: hits on Modified lines stay off the bus
   p_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_cur == LN_M) |-> (bus_cmd == BUS_NONE));

   // R7: a flushed line no longer holds dirty data afterwards
   p_flush_cleans_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> (st_all[$past(snoop_idx)] != LN_M));

   // R8: read-for-ownership from another core removes the copy
   p_rdx_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_vld && snoop_rdx) |=> (st_all[$past(snoop_idx)] == LN_I));

   // R9: the sharer response answers only snooped reads
   p_shared_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      shared_rsp |-> (snoop_vld && !snoop_rdx));

   // R10: nothing answers for a line that is not held
   p_idle_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_vld && snp_cur == LN_I) |-> (!flush_req && !shared_rsp));

   generate
      if (!ALLOW_EXCL) begin : g_chk_msi
         // R3: the three-state variant never shows Exclusive
         p_msi_no_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
            probe_state != LN_E);
      end
   endgenerate

endmodule

// File: tb/sim_coh_line_ctrl.sv
`timescale 1ns/1ps
module sim_coh_line_ctrl;

   localparam int LINES = 16;
   localparam int IW    = 4;
   localparam int HALF  = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_wr = 1'b0;
   logic [IW-1:0] cpu_idx = '0;
   logic          own_shared_in = 1'b0;
   logic          snoop_vld = 1'b0;
   logic          snoop_rdx = 1'b0;
   logic [IW-1:0] snoop_idx = '0;
   logic [IW-1:0] probe_idx = '0;

   logic [1:0] bus0, bus1, st0, st1;
   logic       fl0, fl1, sh0, sh1;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #HALF clk = ~clk;

   coh_line_ctrl #(.LINES(LINES), .ALLOW_EXCL(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
      .cpu_idx(cpu_idx), .own_shared_in(own_shared_in),
      .snoop_vld(snoop_vld), .snoop_rdx(snoop_rdx), .snoop_idx(snoop_idx),
      .probe_idx(probe_idx), .bus_cmd(bus0), .flush_req(fl0),
      .shared_rsp(sh0), .probe_state(st0));

   coh_line_ctrl #(.LINES(LINES), .ALLOW_EXCL(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
      .cpu_idx(cpu_idx), .own_shared_in(own_shared_in),
      .snoop_vld(snoop_vld), .snoop_rdx(snoop_rdx), .snoop_idx(snoop_idx),
      .probe_idx(probe_idx), .bus_cmd(bus1), .flush_req(fl1),
      .shared_rsp(sh1), .probe_state(st1));

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // state check on both variants
   task automatic st_chk(input int idx, input int e0, input int e1, input string tag);
      probe_idx = IW'(idx);
      #1;
      chk({tag, " 4-state"}, int'(st0), e0);
      chk({tag, " 3-state"}, int'(st1), e1);
   endtask

   task automatic cpu_op(input bit wr, input int idx, input bit shr,
                         input int b0, input int b1, input string tag);
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = wr; cpu_idx = IW'(idx); own_shared_in = shr;
      #5;
      chk({tag, " bus 4-state"}, int'(bus0), b0);
      chk({tag, " bus 3-state"}, int'(bus1), b1);
      @(negedge clk);
      cpu_req = 1'b0; cpu_wr = 1'b0; own_shared_in = 1'b0;
   endtask

   task automatic snp_op(input bit rdx, input int idx, input int f0, input int f1,
                         input int s0, input int s1, input string tag);
      @(negedge clk);
      snoop_vld = 1'b1; snoop_rdx = rdx; snoop_idx = IW'(idx);
      #5;
      chk({tag, " flush 4-state"}, int'(fl0), f0);
      chk({tag, " flush 3-state"}, int'(fl1), f1);
      chk({tag, " shared 4-state"}, int'(sh0), s0);
      chk({tag, " shared 3-state"}, int'(sh1), s1);
      @(negedge clk);
      snoop_vld = 1'b0; snoop_rdx = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < LINES; i++) st_chk(i, 0, 0, "R1 reset");
   endtask

   task automatic t_load_miss;
      cpu_op(1'b0, 1, 1'b0, 1, 1, "R2 load miss");
      st_chk(1, 2, 1, "R3 fill alone");
      cpu_op(1'b0, 2, 1'b1, 1, 1, "R2 load miss shared");
      st_chk(2, 1, 1, "R3 fill shared");
   endtask

   task automatic t_store;
      cpu_op(1'b1, 1, 1'b0, 0, 2, "R5 store on excl / R4 store on shared");
      st_chk(1, 3, 3, "R5 R4 store owns");
      cpu_op(1'b1, 2, 1'b0, 2, 2, "R4 store on shared");
      st_chk(2, 3, 3, "R4 store owns");
      cpu_op(1'b1, 6, 1'b0, 2, 2, "R4 store on invalid");
      st_chk(6, 3, 3, "R4 store miss owns");
   endtask

   task automatic t_hits;
      cpu_op(1'b0, 1, 1'b1, 0, 0, "R6 load hit modified");
      cpu_op(1'b1, 1, 1'b0, 0, 0, "R6 store hit modified");
      st_chk(1, 3, 3, "R6 modified kept");
      cpu_op(1'b0, 7, 1'b0, 1, 1, "R2 load miss");
      cpu_op(1'b0, 7, 1'b1, 0, 0, "R6 load hit clean");
      st_chk(7, 2, 1, "R6 clean kept");
   endtask

   task automatic t_snoop_rd;
      snp_op(1'b0, 1, 1, 1, 1, 1, "R7 R9 snoop read modified");
      st_chk(1, 1, 1, "R7 modified to shared");
      snp_op(1'b0, 7, 0, 0, 1, 1, "R7 R9 snoop read clean");
      st_chk(7, 1, 1, "R7 excl to shared");
      snp_op(1'b0, 7, 0, 0, 1, 1, "R7 snoop read shared");
      st_chk(7, 1, 1, "R7 shared kept");
   endtask

   task automatic t_snoop_rdx;
      snp_op(1'b1, 2, 1, 1, 0, 0, "R8 snoop rdx modified");
      st_chk(2, 0, 0, "R8 modified invalidated");
      snp_op(1'b1, 7, 0, 0, 0, 0, "R8 snoop rdx shared");
      st_chk(7, 0, 0, "R8 shared invalidated");
   endtask

   task automatic t_snoop_idle;
      snp_op(1'b0, 5, 0, 0, 0, 0, "R10 snoop read invalid");
      snp_op(1'b1, 5, 0, 0, 0, 0, "R10 snoop rdx invalid");
      st_chk(5, 0, 0, "R10 invalid kept");
   endtask

   task automatic t_concurrent;
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = 1'b0; cpu_idx = 4'd4; own_shared_in = 1'b0;
      snoop_vld = 1'b1; snoop_rdx = 1'b1; snoop_idx = 4'd1;
      #5;
      chk("R11 bus 4-state", int'(bus0), 1);
      chk("R11 bus 3-state", int'(bus1), 1);
      chk("R11 flush 4-state", int'(fl0), 0);
      @(negedge clk);
      cpu_req = 1'b0; snoop_vld = 1'b0; snoop_rdx = 1'b0;
      st_chk(4, 2, 1, "R11 cpu side");
      st_chk(1, 0, 0, "R11 snoop side");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_miss();
      t_store();
      t_hits();
      t_snoop_rd();
      t_snoop_rdx();
      t_snoop_idle();
      t_concurrent();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(2 * HALF * 20000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule